// File: doc/BRIEF.md
# Daisy-chainable serial channel-select controller

This block is the digital control for an eight-way switch matrix. A host drives a three-wire serial port made of a select line, a serial clock and a data line. While the select line is high, every rising serial clock edge moves the data bit into a four-bit frame register. The oldest bit in that register comes out on a serial output, so the output of one device can feed the data input of the next one. A single host port can then program a whole chain of devices with one continuous bit stream. The device nearest the host keeps the last four bits of the stream. The first four bits of the stream travel to the far end of the chain.

When the select line drops, the block turns every switch enable off at once. It then waits a programmable on-delay and turns on the one enable that the frame selects. When the select line rises again to start the next load, the active enable stays on for a programmable off-delay and then drops. Both delays count cycles of a fast system clock. The serial pins are synchronized into that clock domain before any edge is detected. The serial output carries an output-enable so that a pad can be put in three-state while the select line is low.

Top module: `sersel_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the frame register, turns all eight switch enables off, and deasserts dout_oe and frame_err. As a result, with the select line high after reset, ser_dout stays 0 for the first three serial clock rises.
- R2: While ser_cs is high, each rising ser_clk edge shifts ser_din into the frame register. Bits go out MSB first, so a bit driven on ser_din appears on ser_dout after the fourth rising edge.
- R3: A frame is four bits in the order enable bit, then channel code bits 2, 1, 0. Only the last four bits shifted in before ser_cs falls take effect. Earlier bits leave through ser_dout toward downstream devices.
- R4: A frame with enable bit 1 and code c (0 to 7) turns on sw_en bit c alone. A frame with enable bit 0 leaves all sw_en bits at 0, whatever the code. At no time is more than one sw_en bit high.
- R5: When ser_cs falls, all sw_en bits go to 0 first. The selected bit goes high only after ON_DLY system cycles, and sw_en never switches directly from one channel to another. Across a chain loaded with a single active channel, at most one enable is high at any time.
- R6: When ser_cs rises, an active enable stays high for OFF_DLY system cycles and then goes to 0. It stays 0 until the next ser_cs fall and on-delay.
- R7: While ser_cs is low, dout_oe is 0. Serial clock edges then shift nothing: ser_dout holds its value and the switch enables do not change.
- R8: If ser_cs falls after no rising ser_clk edges, or after a number of edges that is not a multiple of four, frame_err pulses high for one cycle. In that case all sw_en bits stay 0.
- R9: With two devices chained, an 8-bit stream {far nibble, near nibble} programs the far device with the first nibble and the near device with the second nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_cs | input | 1 | Serial select; high loads, falling edge applies |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output (frame register MSB) |
| dout_oe | output | 1 | Output-enable for ser_dout; low means three-state |
| sw_en | output | NUM_CH | One-hot switch enables, bit c for channel c |
| frame_err | output | 1 | One-cycle pulse on a framing violation at select fall |

## Verification
The bound checker watches every cycle for four properties: at most one enable high, no direct switch from one channel to another, an enable turning on only while the select line is low, and ser_dout frozen while dout_oe is low. It also checks that a frame error never coincides with an active enable and that the reset state is as stated. Only the bench scenarios can show the rest. These are the actual channel each device picks out of a chained stream, the length of the on-delay and off-delay windows, the discard of early bits in a long stream, and the framing-error cases. A monitor in the bench also confirms that across the two chained devices no more than one enable is ever high.

// File: rtl/sersel_pkg.sv
package sersel_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT_ON,
    SQ_ON,
    SQ_WAIT_OFF
  } seq_state_t;
endpackage

// File: rtl/sersel_sync.sv
module sersel_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/sersel_shift.sv
module sersel_shift #(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_clk,
  input  logic               s_cs,
  input  logic               s_din,
  output logic [FRAME_W-1:0] frame,
  output logic               dout,
  output logic               dout_oe,
  output logic               cs_fall,
  output logic               cs_rise,
  output logic               frame_bad
);
  localparam int CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;

  logic             clk_q, cs_q, seen;
  logic [CNT_W-1:0] bit_cnt;
  logic             clk_rise;

  assign clk_rise  = s_clk & ~clk_q;
  assign cs_fall   = cs_q & ~s_cs;
  assign cs_rise   = ~cs_q & s_cs;
  assign frame_bad = ~seen | (bit_cnt != '0);
  assign dout      = frame[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q   <= 1'b0;
      cs_q    <= 1'b0;
      dout_oe <= 1'b0;
      frame   <= '0;
      bit_cnt <= '0;
      seen    <= 1'b0;
    end else begin
      clk_q   <= s_clk;
      cs_q    <= s_cs;
      dout_oe <= s_cs;
      if (clk_rise && s_cs) begin
        frame <= {frame[FRAME_W-2:0], s_din};
        seen  <= 1'b1;
        if (cs_rise)                           bit_cnt <= CNT_W'(1);
        else if (bit_cnt == CNT_W'(FRAME_W-1)) bit_cnt <= '0;
        else                                   bit_cnt <= bit_cnt + 1'b1;
      end else if (cs_rise) begin
        bit_cnt <= '0;
        seen    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sersel_seq.sv
module sersel_seq
  import sersel_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int ON_DLY  = 8,
  parameter int OFF_DLY = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_fall,
  input  logic                      cs_rise,
  input  logic                      frame_bad,
  input  logic [$clog2(NUM_CH):0]   code,
  output logic [NUM_CH-1:0]         sw_en,
  output logic                      frame_err
);
  localparam int SEL_W   = $clog2(NUM_CH);
  localparam int MAX_DLY = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int DLY_W   = $clog2(MAX_DLY + 2);

  seq_state_t       state;
  logic [DLY_W-1:0] cnt;
  logic [SEL_W:0]   code_q;
  logic [NUM_CH-1:0] dec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign dec[g] = code_q[SEL_W] && (code_q[SEL_W-1:0] == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      code_q    <= '0;
      sw_en     <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (cs_fall) begin
        sw_en <= '0;
        if (frame_bad) begin
          frame_err <= 1'b1;
          state     <= SQ_IDLE;
        end else begin
          code_q <= code;
          cnt    <= DLY_W'(ON_DLY);
          state  <= SQ_WAIT_ON;
        end
      end else begin
        case (state)
          SQ_WAIT_ON: begin
            if (cs_rise)        state <= SQ_IDLE;
            else if (cnt == '0) begin
              sw_en <= dec;
              state <= SQ_ON;
            end else            cnt <= cnt - 1'b1;
          end
          SQ_ON: begin
            if (cs_rise) begin
              if (sw_en == '0) state <= SQ_IDLE;
              else begin
                cnt   <= DLY_W'(OFF_DLY);
                state <= SQ_WAIT_OFF;
              end
            end
          end
          SQ_WAIT_OFF: begin
            if (cnt == '0) begin
              sw_en <= '0;
              state <= SQ_IDLE;
            end else cnt <= cnt - 1'b1;
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sersel_ctrl.sv
module sersel_ctrl #(
  parameter int NUM_CH      = 8,
  parameter int ON_DLY      = 8,
  parameter int OFF_DLY     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_cs,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              dout_oe,
  output logic [NUM_CH-1:0] sw_en,
  output logic              frame_err
);
  localparam int SEL_W   = $clog2(NUM_CH);
  localparam int FRAME_W = SEL_W + 1;

  logic [2:0]         s_pins;
  logic [FRAME_W-1:0] frame;
  logic               cs_fall, cs_rise, frame_bad;

  sersel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ser_clk, ser_cs, ser_din}),
    .sync_out (s_pins)
  );

  sersel_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .s_clk     (s_pins[2]),
    .s_cs      (s_pins[1]),
    .s_din     (s_pins[0]),
    .frame     (frame),
    .dout      (ser_dout),
    .dout_oe   (dout_oe),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .frame_bad (frame_bad)
  );

  sersel_seq #(.NUM_CH(NUM_CH), .ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .frame_bad (frame_bad),
    .code      (frame),
    .sw_en     (sw_en),
    .frame_err (frame_err)
  );
endmodule

// File: rtl/sersel_chk.sv
module sersel_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_dout,
  input logic              dout_oe,
  input logic [NUM_CH-1:0] sw_en,
  input logic              frame_err
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (sw_en == '0 && !dout_oe && !frame_err)); // R1

  AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sw_en)); // R4

  AST_BBM_GAP: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_en) != '0 && sw_en != '0) |-> (sw_en == $past(sw_en))); // R5

  AST_ON_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_en) == '0 && sw_en != '0) |-> !dout_oe); // R5

  AST_HOLD_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> $stable(ser_dout)); // R7

  AST_ERR_NO_ON: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (sw_en == '0)); // R8

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err); // R8
endmodule

bind sersel_ctrl sersel_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ser_dout  (ser_dout),
  .dout_oe   (dout_oe),
  .sw_en     (sw_en),
  .frame_err (frame_err)
);

// File: tb/sim_sersel_ctrl.sv
`timescale 1ns/1ps
module sim_sersel_ctrl;
  localparam int ON_DLY  = 8;
  localparam int OFF_DLY = 4;
  localparam int HALF    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_cs = 1'b0, ser_din = 1'b0;
  logic dout0, oe0, err0, dout1, oe1, err1;
  logic [7:0] sw0, sw1;

  int checks = 0, fails = 0, overlap = 0, errs0 = 0, errs1 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sersel_ctrl #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_cs(ser_cs), .ser_din(ser_din),
    .ser_dout(dout0), .dout_oe(oe0), .sw_en(sw0), .frame_err(err0));

  sersel_ctrl #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u1 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_cs(ser_cs), .ser_din(dout0),
    .ser_dout(dout1), .dout_oe(oe1), .sw_en(sw1), .frame_err(err1));

  always @(negedge clk) begin
    if (!rst) begin
      if ($countones({sw0, sw1}) > 1) overlap++;
      if (err0) errs0++;
      if (err1) errs1++;
    end
  end

  // {stream: far nibble then near nibble, expected far sw_en, expected near sw_en}
  localparam logic [23:0] VEC [6] = '{
    {8'b1101_0000, 8'h20, 8'h00},
    {8'b0011_1011, 8'h00, 8'h08},
    {8'b1000_0111, 8'h01, 8'h00},
    {8'b0000_1111, 8'h00, 8'h80},
    {8'b0110_0000, 8'h00, 8'h00},
    {8'b1111_0101, 8'h80, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wsys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    ser_din = b;
    wsys(HALF/2);
    ser_clk = 1'b1;
    wsys(HALF);
    ser_clk = 1'b0;
    wsys(HALF/2);
  endtask

  task automatic shift_bits(input int n, input logic [15:0] bits);
    for (int i = n - 1; i >= 0; i--) pulse(bits[i]);
  endtask

  task automatic cs_high();
    ser_cs = 1'b1;
    wsys(HALF);
  endtask

  // lower select at a negedge, then check the all-off gap and the final value
  task automatic cs_low_check(input string req, input logic [7:0] e1, input logic [7:0] e0);
    wsys(HALF);
    ser_cs = 1'b0;
    repeat (ON_DLY + 1) @(posedge clk);
    @(negedge clk);
    chk({req, " gap far"}, {24'h0, sw1}, 32'h0);
    chk({req, " gap near"}, {24'h0, sw0}, 32'h0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk({req, " far"}, {24'h0, sw1}, {24'h0, e1});
    chk({req, " near"}, {24'h0, sw0}, {24'h0, e0});
  endtask

  initial begin
    wsys(4);
    chk("R1 sw_en reset", {16'h0, sw1, sw0}, 32'h0);
    chk("R1 dout_oe reset", {30'h0, oe1, oe0}, 32'h0);
    chk("R1 frame_err reset", {30'h0, err1, err0}, 32'h0);
    rst = 1'b0;
    wsys(4);

    // R1 and R2: ones enter, register was cleared, first bit reaches dout on 4th edge
    cs_high();
    chk("R2 dout_oe while select high", {31'h0, oe0}, 32'h1);
    for (int i = 1; i <= 4; i++) begin
      pulse(1'b1);
      if (i < 4) chk("R1 cleared register on dout", {31'h0, dout0}, 32'h0);
      else       chk("R2 bit on dout after 4th edge", {31'h0, dout0}, 32'h1);
    end
    shift_bits(4, 16'b0000);
    cs_low_check("R9 first load", 8'h80, 8'h00);

    // R4, R5, R9: vector table over the chain
    foreach (VEC[k]) begin
      cs_high();
      shift_bits(8, {8'h0, VEC[k][23:16]});
      cs_low_check($sformatf("R4 R9 vec%0d", k), VEC[k][15:8], VEC[k][7:0]);
    end

    // R3: 12-bit stream, the first nibble passes out of the chain
    cs_high();
    shift_bits(12, 16'b1010_0001_1100);
    cs_low_check("R3 long stream", 8'h00, 8'h10);

    // R7: clocks and data while select is low change nothing
    begin
      logic d_before;
      d_before = dout0;
      for (int i = 0; i < 4; i++) pulse(~d_before);
      chk("R7 dout held", {31'h0, dout0}, {31'h0, d_before});
      chk("R7 dout_oe low", {31'h0, oe0}, 32'h0);
      chk("R7 enables held", {24'h0, sw0}, 32'h10);
    end

    // R6: off-delay after select rises
    ser_cs = 1'b1;
    repeat (OFF_DLY + 1) @(posedge clk);
    @(negedge clk);
    chk("R6 still on during off-delay", {24'h0, sw0}, 32'h10);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R6 off after off-delay", {24'h0, sw0}, 32'h0);
    wsys(40);
    chk("R6 stays off while select high", {24'h0, sw0}, 32'h0);

    // R8: select falls with no edges
    errs0 = 0; errs1 = 0;
    ser_cs = 1'b0;
    wsys(ON_DLY + 10);
    chk("R8 zero-edge frame error", errs0, 32'd1);
    chk("R8 zero-edge stays off", {16'h0, sw1, sw0}, 32'h0);

    // R8: five edges, not a multiple of four
    errs0 = 0; errs1 = 0;
    cs_high();
    shift_bits(5, 16'b1_1011);
    cs_low_check("R8 five-edge stays off", 8'h00, 8'h00);
    chk("R8 five-edge error near", errs0, 32'd1);
    chk("R8 five-edge error far", errs1, 32'd1);

    chk("R5 at most one enable across chain", overlap, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule